// File: doc/BRIEF.md
# Host Command Queue Register Window

This block is the controller side of a host bus adapter's register window. The host sees it through a 32-bit memory-mapped bus with separate read and write strobes. Writing to the request port places a command bus address into an inbound queue. An internal command processor drains that queue through a valid/pop interface. The processor posts completion tags into an outbound queue, and the host collects them by reading the reply port.

The window also holds several other registers: an interrupt mask with inverted polarity, an interrupt status register, a readiness scratchpad, a doorbell register, two read-only configuration locators and a sticky request-overflow flag. A single parameter selects between two register variants. They differ only in the bit that masks the interrupt and the bit that reports a pending reply. An empty reply queue reads back as all ones, so no separate empty flag is needed.

Top module: `hba_cmd_window`

## Requirements
- R1: A write to offset 0x40 pushes the write data into the request queue. `req_valid_o` and `req_data_o` present the oldest entry, and a cycle with `req_pop_i` high removes it, so entries leave in the order they were written.
- R2: A read at offset 0x44 returns the oldest completion on `bus_rdata_o` one cycle after the read strobe and removes it. Completions come back in the order they were pushed on `cpl_push_i`/`cpl_data_i`.
- R3: A read at offset 0x44 while the reply queue is empty returns 0xFFFFFFFF and changes no state.
- R4: The interrupt mask register is at offset 0x34 and is masked after reset. The mask bit is bit 3 (bit 2 when `ALT_VARIANT` is 1). Writing 0 in that bit enables the interrupt, and writing 1 there masks it. A read returns only that bit.
- R5: The status register is at offset 0x30. Bit 3 (bit 2 when `ALT_VARIANT` is 1) reads 1 while the reply queue holds an entry, whatever the mask setting. All other bits read 0.
- R6: `irq_o` is a register that, one cycle later, equals "reply queue not empty AND interrupt not masked".
- R7: The scratchpad at offset 0xB0 reads 0xFFFF0000 while `fw_ready_i` is high and 0 while it is low.
- R8: A request write while the request queue is full is discarded and sets a sticky overflow flag. The flag reads as bit 0 at offset 0x48 and is cleared by that read.
- R9: Reads from unmapped offsets return 0. Writes to unmapped offsets change nothing.
- R10: The doorbell register at offset 0x20 is read/write and resets to 0. Offsets 0xB4 and 0xB8 read the parameters `CFG_TBL_OFS` and `CFG_MEM_OFS`.
- R11: With `ALT_VARIANT` = 1, the mask reads back as 0x4 after reset, and the status register reads 0x4 while a reply is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | ADDR_W | Byte offset within the window |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Reply interrupt |
| fw_ready_i | input | 1 | Command processor ready for commands |
| req_valid_o | output | 1 | Request queue holds an entry |
| req_data_o | output | 32 | Oldest request address |
| req_pop_i | input | 1 | Consume the oldest request |
| cpl_push_i | input | 1 | Post a completion |
| cpl_data_i | input | 32 | Completion tag |
| cpl_full_o | output | 1 | Reply queue full |

## Verification
The bench reads the reply port while the queue is empty and then confirms that the status and later completions are undisturbed. A design that popped or decremented on an empty read would lose or reorder tags. It fills the request queue past its depth and checks that the extra address is gone and that the overflow flag clears on its first read. A design that wrapped its pointer would overwrite the oldest command.

The bench samples `irq_o` in the cycles right after each mask write and each pop, which exposes an off-by-one in the interrupt register or a mask with the wrong polarity. A second instance with the alternate variant shares the same bus, so a wrong bit position in either variant shows up directly on the status and mask reads.

// File: rtl/hba_win_pkg.sv
package hba_win_pkg;
  localparam int unsigned DW = 32;

  localparam int unsigned OFS_DOORBELL = 'h20;
  localparam int unsigned OFS_STATUS   = 'h30;
  localparam int unsigned OFS_MASK     = 'h34;
  localparam int unsigned OFS_REQ      = 'h40;
  localparam int unsigned OFS_RPL      = 'h44;
  localparam int unsigned OFS_OVF      = 'h48;
  localparam int unsigned OFS_SCRATCH  = 'hB0;
  localparam int unsigned OFS_CFG_TBL  = 'hB4;
  localparam int unsigned OFS_CFG_MEM  = 'hB8;

  localparam logic [DW-1:0] RPL_EMPTY_WORD = '1;
  localparam logic [DW-1:0] READY_WORD     = 32'hFFFF_0000;
endpackage

// File: rtl/hba_word_fifo.sv
module hba_word_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] push_data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [$clog2(DEPTH):0] count_o
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH) + 1;

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [AW-1:0]    wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]    count_q;
  logic             do_push, do_pop;

  assign empty_o = (count_q == '0);
  assign full_o  = (count_q == CW'(DEPTH));
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem_q[rd_ptr_q];
  assign count_o = count_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      always_ff @(posedge clk_i) begin
        if (do_push && wr_ptr_q == AW'(i)) mem_q[i] <= push_data_i;
      end
    end
  endgenerate

  // R1 / R2: occupancy tracks accepted pushes and pops
  a_r1_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CW'(DEPTH));
  a_r1_push_grows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !full_o && !pop_i) |=> (count_q == $past(count_q) + 1'b1));
  a_r2_pop_shrinks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !empty_o && !push_i) |=> (count_q == $past(count_q) - 1'b1));
endmodule

// File: rtl/hba_irq_ctrl.sv
module hba_irq_ctrl #(
  parameter int unsigned MASK_POS = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic mask_we_i,
  input  logic mask_bit_i,
  input  logic pending_i,
  output logic masked_o,
  output logic irq_o
);
  logic masked_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      masked_q <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      if (mask_we_i) masked_q <= mask_bit_i;
      irq_q <= pending_i && !masked_q;
    end
  end

  assign masked_o = masked_q;
  assign irq_o    = irq_q;

  // R6: interrupt only from a pending, unmasked reply one cycle earlier
  a_r6_irq_needs_pending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |-> $past(pending_i));
  a_r6_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    masked_q |=> !irq_q);
  // R4: mask changes only through a mask write
  a_r4_mask_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mask_we_i |=> $stable(masked_q));
endmodule

// File: rtl/hba_cmd_window.sv
module hba_cmd_window
  import hba_win_pkg::*;
#(
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned REQ_DEPTH   = 4,
  parameter int unsigned RPL_DEPTH   = 4,
  parameter bit          ALT_VARIANT = 1'b0,
  parameter logic [31:0] CFG_TBL_OFS = 32'h0000_1000,
  parameter logic [31:0] CFG_MEM_OFS = 32'h0000_2000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o,
  input  logic              fw_ready_i,
  output logic              req_valid_o,
  output logic [31:0]       req_data_o,
  input  logic              req_pop_i,
  input  logic              cpl_push_i,
  input  logic [31:0]       cpl_data_i,
  output logic              cpl_full_o
);
  localparam int unsigned BIT_POS = ALT_VARIANT ? 2 : 3;
  localparam int unsigned RQ_CW   = $clog2(REQ_DEPTH) + 1;
  localparam int unsigned RP_CW   = $clog2(RPL_DEPTH) + 1;

  logic [31:0] rdata_q, rdata_d, doorbell_q, rpl_head;
  logic        ovf_q;
  logic        hit_req, hit_rpl, hit_ovf, hit_mask, hit_db;
  logic        req_push, req_full, req_empty, req_drop;
  logic        rpl_pop, rpl_empty, masked;
  logic [RQ_CW-1:0] req_count;
  logic [RP_CW-1:0] rpl_count;

  assign hit_req  = (bus_addr_i == ADDR_W'(OFS_REQ));
  assign hit_rpl  = (bus_addr_i == ADDR_W'(OFS_RPL));
  assign hit_ovf  = (bus_addr_i == ADDR_W'(OFS_OVF));
  assign hit_mask = (bus_addr_i == ADDR_W'(OFS_MASK));
  assign hit_db   = (bus_addr_i == ADDR_W'(OFS_DOORBELL));

  assign req_push = bus_wr_i && hit_req;
  assign req_drop = req_push && req_full;
  assign rpl_pop  = bus_rd_i && hit_rpl && !rpl_empty;

  hba_word_fifo #(.WIDTH(32), .DEPTH(REQ_DEPTH)) u_req_q (
    .clk_i, .rst_ni,
    .push_i(req_push), .push_data_i(bus_wdata_i),
    .pop_i(req_pop_i), .head_o(req_data_o),
    .empty_o(req_empty), .full_o(req_full), .count_o(req_count)
  );

  hba_word_fifo #(.WIDTH(32), .DEPTH(RPL_DEPTH)) u_rpl_q (
    .clk_i, .rst_ni,
    .push_i(cpl_push_i), .push_data_i(cpl_data_i),
    .pop_i(rpl_pop), .head_o(rpl_head),
    .empty_o(rpl_empty), .full_o(cpl_full_o), .count_o(rpl_count)
  );

  hba_irq_ctrl #(.MASK_POS(BIT_POS)) u_irq (
    .clk_i, .rst_ni,
    .mask_we_i(bus_wr_i && hit_mask),
    .mask_bit_i(bus_wdata_i[BIT_POS]),
    .pending_i(!rpl_empty),
    .masked_o(masked),
    .irq_o(irq_o)
  );

  assign req_valid_o = !req_empty;

  always_comb begin
    rdata_d = '0;
    case (bus_addr_i)
      ADDR_W'(OFS_DOORBELL): rdata_d = doorbell_q;
      ADDR_W'(OFS_STATUS):   rdata_d[BIT_POS] = !rpl_empty;
      ADDR_W'(OFS_MASK):     rdata_d[BIT_POS] = masked;
      ADDR_W'(OFS_RPL):      rdata_d = rpl_empty ? RPL_EMPTY_WORD : rpl_head;
      ADDR_W'(OFS_OVF):      rdata_d[0] = ovf_q;
      ADDR_W'(OFS_SCRATCH):  rdata_d = fw_ready_i ? READY_WORD : '0;
      ADDR_W'(OFS_CFG_TBL):  rdata_d = CFG_TBL_OFS;
      ADDR_W'(OFS_CFG_MEM):  rdata_d = CFG_MEM_OFS;
      default:               rdata_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q    <= '0;
      doorbell_q <= '0;
      ovf_q      <= 1'b0;
    end else begin
      if (bus_rd_i) rdata_q <= rdata_d;
      if (bus_wr_i && hit_db) doorbell_q <= bus_wdata_i;
      // set beats clear when both land in one cycle
      if (req_drop) ovf_q <= 1'b1;
      else if (bus_rd_i && hit_ovf) ovf_q <= 1'b0;
    end
  end

  assign bus_rdata_o = rdata_q;

  a_r2_pop_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rpl_pop |=> (bus_rdata_o == $past(rpl_head)));
  a_r3_empty_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && hit_rpl && rpl_empty) |=> (bus_rdata_o == RPL_EMPTY_WORD));
  a_r3_empty_no_change: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && hit_rpl && rpl_empty && !cpl_push_i) |=> (rpl_count == '0));
  a_r5_status_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_rd_i && bus_addr_i == ADDR_W'(OFS_STATUS)) |=>
      (bus_rdata_o[BIT_POS] == $past(rpl_count != '0)));
  a_r8_drop_keeps_count: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_drop && !req_pop_i) |=> (req_count == $past(req_count)));
  a_r8_ovf_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_q && !(bus_rd_i && hit_ovf)) |=> ovf_q);
  a_r8_ovf_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_drop |=> ovf_q);
endmodule

// File: tb/hba_cmd_window_bench.sv
module hba_cmd_window_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0;
  logic        fw_ready = 1'b1;
  logic        req_pop = 1'b0;
  logic        cpl_push = 1'b0;
  logic [31:0] cpl_data = '0;

  logic [31:0] rdata, rdata_alt, req_data, req_data_alt;
  logic        irq, irq_alt, req_valid, req_valid_alt, cpl_full, cpl_full_alt;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  hba_cmd_window u_hba_cmd_window (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_o(irq), .fw_ready_i(fw_ready),
    .req_valid_o(req_valid), .req_data_o(req_data), .req_pop_i(req_pop),
    .cpl_push_i(cpl_push), .cpl_data_i(cpl_data), .cpl_full_o(cpl_full)
  );

  hba_cmd_window #(.ALT_VARIANT(1'b1)) u_hba_cmd_window_alt (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata_alt), .irq_o(irq_alt), .fw_ready_i(fw_ready),
    .req_valid_o(req_valid_alt), .req_data_o(req_data_alt), .req_pop_i(req_pop),
    .cpl_push_i(cpl_push), .cpl_data_i(cpl_data), .cpl_full_o(cpl_full_alt)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // each op: drive at negedge, capture at posedge, settle at next negedge
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a);
    @(negedge clk); addr = a; rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic post_cpl(input logic [31:0] d);
    @(negedge clk); cpl_data = d; cpl_push = 1'b1;
    @(negedge clk); cpl_push = 1'b0;
  endtask

  task automatic pop_req();
    @(negedge clk); req_pop = 1'b1;
    @(negedge clk); req_pop = 1'b0;
  endtask

  // {req tag number, op (0 write, 1 read, 2 completion), addr, data, expected}
  localparam int NV = 17;
  localparam logic [81:0] VEC [NV] = '{
    {8'd7,  2'd1, 8'hB0, 32'h0,         32'hFFFF_0000}, // R7
    {8'd5,  2'd1, 8'h30, 32'h0,         32'h0000_0000}, // R5
    {8'd3,  2'd1, 8'h44, 32'h0,         32'hFFFF_FFFF}, // R3
    {8'd4,  2'd1, 8'h34, 32'h0,         32'h0000_0008}, // R4
    {8'd10, 2'd0, 8'h20, 32'hA5A5_0001, 32'h0},         // R10
    {8'd10, 2'd1, 8'h20, 32'h0,         32'hA5A5_0001},
    {8'd10, 2'd1, 8'hB4, 32'h0,         32'h0000_1000},
    {8'd10, 2'd1, 8'hB8, 32'h0,         32'h0000_2000},
    {8'd2,  2'd2, 8'h00, 32'h1111_0000, 32'h0},         // R2
    {8'd2,  2'd2, 8'h00, 32'h2222_0000, 32'h0},
    {8'd5,  2'd1, 8'h30, 32'h0,         32'h0000_0008},
    {8'd2,  2'd1, 8'h44, 32'h0,         32'h1111_0000},
    {8'd2,  2'd1, 8'h44, 32'h0,         32'h2222_0000},
    {8'd3,  2'd1, 8'h44, 32'h0,         32'hFFFF_FFFF},
    {8'd3,  2'd1, 8'h30, 32'h0,         32'h0000_0000},
    {8'd9,  2'd0, 8'h60, 32'h0000_DEAD, 32'h0},         // R9
    {8'd9,  2'd1, 8'h60, 32'h0,         32'h0000_0000}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R6 reset irq", {31'b0, irq}, 32'h0);
    chk("R1 reset req_valid", {31'b0, req_valid}, 32'h0);
    chk("R2 reset cpl_full", {31'b0, cpl_full}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [81:0] v = VEC[i];
      case (v[73:72])
        2'd0: bus_wr(v[71:64], v[63:32]);
        2'd1: begin
          bus_rd(v[71:64]);
          chk($sformatf("R%0d row %0d", v[81:74], i), rdata, v[31:0]);
        end
        default: post_cpl(v[63:32]);
      endcase
    end
    chk("R9 unmapped write left request queue empty", {31'b0, req_valid}, 32'h0);

    // R11: alternate variant bit positions
    bus_rd(8'h34);
    chk("R11 alt mask reset", rdata_alt, 32'h4);
    chk("R4 main mask reset", rdata, 32'h8);
    post_cpl(32'h0000_00AB);
    bus_rd(8'h30);
    chk("R11 alt status pending", rdata_alt, 32'h4);
    chk("R5 main status pending", rdata, 32'h8);
    bus_rd(8'h44);
    chk("R2 drain", rdata, 32'h0000_00AB);

    // R1: ordering through the back end
    bus_wr(8'h40, 32'h1000_0040);
    bus_wr(8'h40, 32'h1000_0080);
    bus_wr(8'h40, 32'h1000_00C0);
    chk("R1 head first", req_data, 32'h1000_0040);
    pop_req();
    chk("R1 head second", req_data, 32'h1000_0080);
    pop_req();
    chk("R1 head third", req_data, 32'h1000_00C0);
    pop_req();
    chk("R1 queue empty", {31'b0, req_valid}, 32'h0);

    // R8: overflow drop and sticky flag
    for (int k = 0; k < 5; k++) bus_wr(8'h40, 32'h2000_0000 + 32'(k));
    bus_rd(8'h48);
    chk("R8 overflow set", rdata, 32'h1);
    bus_rd(8'h48);
    chk("R8 overflow cleared by read", rdata, 32'h0);
    for (int k = 0; k < 4; k++) begin
      chk("R8 kept entry", req_data, 32'h2000_0000 + 32'(k));
      pop_req();
    end
    chk("R8 fifth write dropped", {31'b0, req_valid}, 32'h0);

    // R4 / R6: mask polarity and interrupt latency
    post_cpl(32'h0000_0077);
    chk("R6 masked no irq", {31'b0, irq}, 32'h0);
    bus_wr(8'h34, 32'h0);
    chk("R6 irq one cycle after unmask", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R6 irq asserted", {31'b0, irq}, 32'h1);
    bus_rd(8'h34);
    chk("R4 mask reads enabled", rdata, 32'h0);
    bus_wr(8'h34, 32'h8);
    chk("R6 irq lags mask", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq dropped after mask", {31'b0, irq}, 32'h0);
    bus_wr(8'h34, 32'h0);
    @(negedge clk);
    chk("R6 irq back", {31'b0, irq}, 32'h1);
    bus_rd(8'h44);
    chk("R2 pop value", rdata, 32'h0000_0077);
    chk("R6 irq lags pop", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R6 irq cleared after pop", {31'b0, irq}, 32'h0);

    // R7: not ready
    fw_ready = 1'b0;
    bus_rd(8'hB0);
    chk("R7 not ready", rdata, 32'h0);

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule